// File: doc/BRIEF.md
# MSI Doorbell Vector Decoder

This block receives message-signalled interrupt writes on a simple register bus and turns each one into a level on one of a set of local interrupt lines. A device raises an interrupt by writing a global vector number into an 8-byte doorbell window. The decoder takes the low byte of the write data as that vector and subtracts a configured base vector. It then checks that the result falls inside the local line range and sets the matching output line. The downstream interrupt controller clears each line by pulsing its own acknowledge input.

The window sits at a parameterised address, and data in it is little-endian. The vector therefore travels in byte lane 0. Reads inside the window are harmless and return zero. A write that cannot be mapped to a line is dropped, and it is counted on a saturating error counter so that misprogrammed sources can be spotted.

Top module: `msi_doorbell_decoder`

## Requirements
- R1: An access is decoded only when busAddr[ADDR_W-1:3] equals WIN_ADDR[ADDR_W-1:3]. All eight byte offsets inside the window behave the same, and a write outside the window changes neither irqOut nor errCount.
- R2: busRdData is always zero, and a read (busRdEn high, busWrEn low) changes neither irqOut nor errCount.
- R3: Only busWrData[7:0] forms the vector and all higher data bits are ignored. A window write with busStrb[0] low is ignored completely and is not counted as an error.
- R4: The local index is the vector minus IRQ_BASE. A vector below IRQ_BASE, or one whose index is NUM_IRQ or more, sets no line.
- R5: An accepted write sets irqOut[index] at the first rising clock edge on which the write strobe is high, with no wait states.
- R6: Each window write with busStrb[0] high that R4 rejects raises errCount by one, and errCount stops at all-ones. Accepted writes leave errCount unchanged.
- R7: A set line stays high until its irqAck bit is high at a clock edge, and an acknowledge clears only its own line.
- R8: If an accepted write and the acknowledge for the same line fall in the same cycle, the line stays set.
- R9: A synchronous active-high reset clears every irqOut line and errCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrData | input | DATA_W | Write data; the vector is in bits [7:0] |
| busStrb | input | DATA_W/8 | Byte-lane write enables |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W | Read data, always zero |
| irqAck | input | NUM_IRQ | Per-line clear pulses |
| irqOut | output | NUM_IRQ | Local interrupt lines |
| errCount | output | ERR_W | Saturating count of rejected writes |

## Verification
The bench targets the edges of the valid vector range: the base itself, the last valid vector, the first one past it, and a vector just below the base. A design with an off-by-one bound would set a line it must not set, or drop one it must set, and a design without the lower bound would wrap the difference onto a high line. It also writes vectors with junk in the upper data bits and with lane 0 disabled, which exposes decoders that use the wrong byte. It checks the same-cycle set and acknowledge case, where a design that gives the acknowledge priority would lose an interrupt. Finally it drives the error counter past all-ones, where a counter that is not saturated would wrap to zero.

// File: rtl/msi_dbl_pkg.sv
package msi_dbl_pkg;

  localparam int VEC_W = 8;  // vector lives in byte lane 0
  localparam int WIN_OFF_W = 3;  // 8-byte doorbell window

  typedef struct packed {
    logic setEn;   // accepted write: set the indexed line
    logic errInc;  // rejected write: bump the error counter
  } ctrlStrobes_t;

endpackage

// File: rtl/msi_dbl_ctrl.sv
module msi_dbl_ctrl
  import msi_dbl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] WIN_ADDR = '0,
  parameter int DATA_W = 32,
  parameter int IRQ_BASE = 0,
  parameter int NUM_IRQ = 32,
  parameter int IDX_W = 5
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [DATA_W/8-1:0] busStrb,
  input  logic                busWrEn,
  input  logic                busRdEn,
  output logic [DATA_W-1:0]   busRdData,
  output ctrlStrobes_t        strobes,
  output logic [IDX_W-1:0]    setIdx
);

  localparam int EXT_W = VEC_W + 1;
  localparam logic [EXT_W-1:0] BASE_EXT = EXT_W'(IRQ_BASE);
  localparam logic [EXT_W-1:0] COUNT_EXT = EXT_W'(NUM_IRQ);

  logic windowHit;
  logic wrTake;
  logic [EXT_W-1:0] vecExt;
  logic [EXT_W-1:0] rebased;
  logic inRange;
  logic unusedBits;

  assign windowHit = busAddr[ADDR_W-1:WIN_OFF_W] == WIN_ADDR[ADDR_W-1:WIN_OFF_W];
  assign wrTake = busWrEn && windowHit && busStrb[0];

  always_comb begin
    vecExt = {1'b0, busWrData[VEC_W-1:0]};
    rebased = vecExt - BASE_EXT;
    inRange = (vecExt >= BASE_EXT) && (rebased < COUNT_EXT);
  end

  assign setIdx = rebased[IDX_W-1:0];
  assign strobes.setEn = wrTake && inRange;
  assign strobes.errInc = wrTake && !inRange;

  // Reads have no side effect and always see zero.
  assign busRdData = '0;
  assign unusedBits = ^{busRdEn, busAddr[WIN_OFF_W-1:0],
                        busWrData[DATA_W-1:VEC_W], busStrb[DATA_W/8-1:1],
                        rebased[EXT_W-1:IDX_W]};

endmodule

// File: rtl/msi_dbl_datapath.sv
module msi_dbl_datapath
  import msi_dbl_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int IDX_W = 5,
  parameter int ERR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   setIdx,
  input  logic [NUM_IRQ-1:0] irqAck,
  output logic [NUM_IRQ-1:0] irqOut,
  output logic [ERR_W-1:0]   errCount
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic hitMe;
    assign hitMe = strobes.setEn && (setIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        irqOut[i] <= 1'b0;
      end else if (hitMe) begin
        irqOut[i] <= 1'b1;  // a new set wins over a same-cycle ack
      end else if (irqAck[i]) begin
        irqOut[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errCount <= '0;
    end else if (strobes.errInc && errCount != ERR_MAX) begin
      errCount <= errCount + ERR_W'(1);
    end
  end

endmodule

// File: rtl/msi_doorbell_decoder.sv
module msi_doorbell_decoder
  import msi_dbl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] WIN_ADDR = '0,
  parameter int DATA_W = 32,
  parameter int IRQ_BASE = 0,
  parameter int NUM_IRQ = 32,
  parameter int MAX_IRQ = 256,
  parameter int ERR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [DATA_W/8-1:0] busStrb,
  input  logic                busWrEn,
  input  logic                busRdEn,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_IRQ-1:0]  irqAck,
  output logic [NUM_IRQ-1:0]  irqOut,
  output logic [ERR_W-1:0]    errCount
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  if (NUM_IRQ < 1 || NUM_IRQ > MAX_IRQ || MAX_IRQ > 256) begin : g_bad_count
    $error("msi_doorbell_decoder: NUM_IRQ out of range");
  end
  if (IRQ_BASE < 0 || IRQ_BASE > 255) begin : g_bad_base
    $error("msi_doorbell_decoder: IRQ_BASE out of range");
  end
  if (DATA_W < 16 || ADDR_W <= WIN_OFF_W) begin : g_bad_bus
    $error("msi_doorbell_decoder: bus widths too small");
  end

  ctrlStrobes_t strobes;
  logic [IDX_W-1:0] setIdx;

  msi_dbl_ctrl #(
    .ADDR_W(ADDR_W), .WIN_ADDR(WIN_ADDR), .DATA_W(DATA_W),
    .IRQ_BASE(IRQ_BASE), .NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)
  ) u_ctrl (
    .busAddr(busAddr), .busWrData(busWrData), .busStrb(busStrb),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .strobes(strobes), .setIdx(setIdx)
  );

  msi_dbl_datapath #(
    .NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W), .ERR_W(ERR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .setIdx(setIdx),
    .irqAck(irqAck), .irqOut(irqOut), .errCount(errCount)
  );

endmodule

// File: rtl/msi_doorbell_decoder_chk.sv
module msi_doorbell_decoder_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] WIN_ADDR = '0,
  parameter int DATA_W = 32,
  parameter int IRQ_BASE = 0,
  parameter int NUM_IRQ = 32,
  parameter int ERR_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWrData,
  input logic [DATA_W/8-1:0] busStrb,
  input logic                busWrEn,
  input logic [NUM_IRQ-1:0]  irqAck,
  input logic [NUM_IRQ-1:0]  irqOut,
  input logic [ERR_W-1:0]    errCount
);

  logic wrOk;
  logic inRng;
  int vecInt;
  int lineSel;

  assign wrOk = busWrEn && busStrb[0] && (busAddr[ADDR_W-1:3] == WIN_ADDR[ADDR_W-1:3]);
  assign vecInt = int'(busWrData[7:0]);
  assign lineSel = vecInt - IRQ_BASE;
  assign inRng = (vecInt >= IRQ_BASE) && (lineSel < NUM_IRQ);

  AST_LINE_SET: assert property (@(posedge clk) disable iff (rst)
    (wrOk && inRng) |=> irqOut[$past(lineSel)]); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    !(wrOk && inRng) |=> ((irqOut & ~$past(irqOut)) == '0)); // R2

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(irqOut) & ~$past(irqAck) & ~irqOut) == '0)); // R7

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wrOk && !inRng && errCount != '1) |=> errCount == $past(errCount) + ERR_W'(1)); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(wrOk && !inRng) |=> $stable(errCount)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (irqOut == '0 && errCount == '0)); // R9

endmodule

bind msi_doorbell_decoder msi_doorbell_decoder_chk #(
  .ADDR_W(ADDR_W), .WIN_ADDR(WIN_ADDR), .DATA_W(DATA_W),
  .IRQ_BASE(IRQ_BASE), .NUM_IRQ(NUM_IRQ), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
  .busStrb(busStrb), .busWrEn(busWrEn), .irqAck(irqAck),
  .irqOut(irqOut), .errCount(errCount)
);

// File: tb/msi_doorbell_decoder_test.sv
module msi_doorbell_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] WIN = 12'h120;
  localparam int DATA_W = 32;
  localparam int BASE = 16;
  localparam int NIRQ = 24;
  localparam int ERR_W = 4;
  localparam int NVEC = 8;

  // stimulus data, byte offset in window, expected line (-1 = rejected)
  localparam logic [31:0] TV_DATA[NVEC] = '{32'h0000_0010, 32'hABCD_EF27, 32'h0000_0028,
                                            32'h0000_000F, 32'hFFFF_FF15, 32'h0000_00FF,
                                            32'h0000_0000, 32'h1234_561C};
  localparam int TV_OFF[NVEC] = '{0, 7, 3, 1, 4, 2, 5, 6};
  localparam int TV_LINE[NVEC] = '{0, 23, -1, -1, 5, -1, -1, 12};

  logic clk = 0;
  logic rst = 1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [3:0] busStrb = '0;
  logic busWrEn = 0;
  logic busRdEn = 0;
  logic [DATA_W-1:0] busRdData;
  logic [NIRQ-1:0] irqAck = '0;
  logic [NIRQ-1:0] irqOut;
  logic [ERR_W-1:0] errCount;

  int nTests = 0;
  int nFail = 0;
  int expErr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_doorbell_decoder #(
    .ADDR_W(ADDR_W), .WIN_ADDR(WIN), .DATA_W(DATA_W), .IRQ_BASE(BASE),
    .NUM_IRQ(NIRQ), .MAX_IRQ(256), .ERR_W(ERR_W)
  ) uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
    .busStrb(busStrb), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busRdData(busRdData), .irqAck(irqAck), .irqOut(irqOut), .errCount(errCount)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    busAddr = a; busWrData = d; busStrb = s; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0; busStrb = '0;
  endtask

  task automatic ackLines(logic [NIRQ-1:0] m);
    @(negedge clk);
    irqAck = m;
    @(negedge clk);
    irqAck = '0;
  endtask

  task automatic bumpErr();
    if (expErr < (1 << ERR_W) - 1) expErr++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    check("R9 reset lines", 64'(irqOut), 64'h0);
    check("R9 reset errCount", 64'(errCount), 64'h0);
    check("R2 rdData idle", 64'(busRdData), 64'h0);

    // table of vectors through the window
    for (int k = 0; k < NVEC; k++) begin
      busWrite(WIN + ADDR_W'(TV_OFF[k]), TV_DATA[k], 4'hF);
      if (TV_LINE[k] < 0) bumpErr();
      check(TV_LINE[k] < 0 ? "R4 rejected vector" : "R5 R3 accepted vector",
            64'(irqOut), TV_LINE[k] < 0 ? 64'h0 : (64'h1 << TV_LINE[k]));
      check("R6 errCount", 64'(errCount), 64'(expErr));
      ackLines('1);
    end

    // write outside the window: no effect (R1)
    busWrite(WIN + 12'h8, 32'h11, 4'hF);
    busWrite(WIN - 12'h1, 32'h11, 4'hF);
    check("R1 outside window lines", 64'(irqOut), 64'h0);
    check("R1 outside window err", 64'(errCount), 64'(expErr));

    // lane 0 disabled: ignored, not counted (R3)
    busWrite(WIN, 32'h11, 4'hE);
    busWrite(WIN, 32'hFF, 4'hE);
    check("R3 lane0 off lines", 64'(irqOut), 64'h0);
    check("R3 lane0 off err", 64'(errCount), 64'(expErr));

    // read with valid vector on data: no side effect, zero data (R2)
    @(negedge clk);
    busAddr = WIN + 12'h2; busWrData = 32'h12; busStrb = 4'hF; busRdEn = 1;
    #1 check("R2 read data zero", 64'(busRdData), 64'h0);
    @(negedge clk);
    busRdEn = 0; busStrb = '0;
    check("R2 read no line", 64'(irqOut), 64'h0);
    check("R2 read no err", 64'(errCount), 64'(expErr));

    // hold and selective ack (R7)
    busWrite(WIN, 32'h13, 4'h1);  // line 3
    busWrite(WIN, 32'h19, 4'h1);  // line 9
    repeat (5) @(negedge clk);
    check("R7 lines held", 64'(irqOut), 64'h208);
    ackLines(NIRQ'(1) << 3);
    check("R7 ack clears only own line", 64'(irqOut), 64'h200);

    // set and ack of same line in one cycle (R8)
    @(negedge clk);
    busAddr = WIN; busWrData = 32'h19; busStrb = 4'h1; busWrEn = 1;
    irqAck = NIRQ'(1) << 9;
    @(negedge clk);
    busWrEn = 0; irqAck = '0;
    check("R8 set beats ack", 64'(irqOut), 64'h200);
    ackLines('1);
    check("R7 ack all", 64'(irqOut), 64'h0);

    // error counter saturation (R6)
    for (int k = 0; k < 20; k++) begin
      busWrite(WIN + 12'h4, 32'h0000_0030, 4'hF);
      bumpErr();
    end
    check("R6 saturation", 64'(errCount), 64'hF);
    busWrite(WIN, 32'h14, 4'h1);
    check("R6 accepted leaves err", 64'(errCount), 64'hF);

    // synchronous reset clears state (R9)
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R9 reset clears lines", 64'(irqOut), 64'h0);
    check("R9 reset clears err", 64'(errCount), 64'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nTests++;
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule